// File: doc/BRIEF.md
# Address-Mapping Metadata Cache with Presence Filter

This block keeps address-mapping metadata on chip. Each cache entry holds a single mapping, a key and the value it maps to. The entries are arranged 4 ways by 16 sets, and the least recently used way in a set is the one replaced. A client sends two kinds of request through one port: a read that looks a key up, and an update that writes a key. Reads get a response. Updates are absorbed silently and leave the entry dirty.

When a read misses, the block first asks a 1024-bit presence filter whether the key was ever sent off chip. Only dirty entries leave the chip, and only when they are evicted; at that moment the key is recorded in the filter. If the filter rules the key out, the read is answered on the next cycle as "no mapping" and a filtered-miss pulse is raised. Otherwise the block issues one read for the whole memory line of eight neighbouring mappings. It then installs every valid mapping of that line, one per cycle, so that the neighbours are prefetched along with the key that was asked for. The requested slot is answered at the end of the fill.

Only one memory read can be in flight at a time. The request port stays not-ready from the moment that read is issued until the fill is complete.

Top module: `mdc_meta_cache`

## Requirements
- R1: After reset no key is resident and the filter is empty: lk_ready is 1, and a read of any key is answered one cycle after acceptance with rs_found=0 and filt_miss=1, with no memory request.
- R2: A read of a resident key is answered one cycle after acceptance with rs_found=1 and the stored value, with no memory request.
- R3: An update of a resident key replaces its value, marks it dirty and makes it most recently used; an update produces no response.
- R4: An update of a non-resident key is installed dirty in the least recently used way of set key[3:0]. If that victim is dirty, a memory write is issued with mem_req_addr equal to the victim key and mem_req_wdata equal to its value.
- R5: A clean victim is dropped without any memory write.
- R6: Every evicted dirty key is inserted into the filter. A later read miss on that key issues exactly one memory read whose address is the key with its low 3 bits cleared.
- R7: A read miss whose key does not have both filter bits set completes as a filtered miss (rs_found=0, filt_miss=1, one cycle after acceptance) with no memory request. The two bit indices are the XOR of the 10-bit chunks of the zero-padded key, and the same fold applied to the key rotated left by 5.
- R8: A line response carries key base+i in mem_rsp_data[i*16 +: 16], valid when mem_rsp_mask[i] is 1. Every valid slot is installed clean, so later reads of those keys hit without memory traffic.
- R9: After the fill, the read is answered with rs_found equal to the mask bit of the requested slot, and the value from that slot.
- R10: From the memory read request until the fill ends, lk_ready stays 0.
- R11: A fill slot whose key is already resident is skipped, and the resident value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Request valid |
| lk_ready | output | 1 | Block can accept a request |
| lk_write | input | 1 | 1 = update, 0 = read |
| lk_key | input | 16 | Mapping key |
| lk_wdata | input | 16 | Value for an update |
| rs_valid | output | 1 | Read response valid |
| rs_found | output | 1 | A mapping exists for the key |
| rs_data | output | 16 | Mapped value (0 when not found) |
| filt_miss | output | 1 | Read miss answered by the filter without memory access |
| mem_req_valid | output | 1 | Memory request, always accepted |
| mem_req_write | output | 1 | 1 = write one mapping, 0 = read a line |
| mem_req_addr | output | 16 | Key for a write, line base key for a read |
| mem_req_wdata | output | 16 | Value for a write |
| mem_rsp_valid | input | 1 | Line response pulse |
| mem_rsp_data | input | 128 | Eight mapping values, slot i at bits i*16 |
| mem_rsp_mask | input | 8 | Validity of each slot |

## Verification
The hardest state to reach from the ports is a fill that lands on a line where one key is dirty and still resident. To get there, the filter must first hold the trigger key, and that only happens after an eviction. The stimulus therefore fills one set with five updates so that a dirty key is pushed out and recorded. It then updates a different key of the same memory line and preloads an older copy of that key in the bench memory. Finally it reads the evicted key back, which shows both the line-address read and the skip of the resident slot.

// File: rtl/mdc_pkg.sv
package mdc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_FILL = 2'd2
    } mdc_state_e;
endpackage

// File: rtl/mdc_bloom.sv
module mdc_bloom #(
    parameter int KEY_W = 16,
    parameter int BITS  = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] q_key,
    output logic             q_maybe,
    input  logic             ins_en,
    input  logic [KEY_W-1:0] ins_key
);
    localparam int HW  = $clog2(BITS);
    localparam int NCH = (KEY_W + HW - 1) / HW;
    localparam int ROT = HW / 2;

    logic [BITS-1:0] bits_d, bits_q;

    function automatic logic [HW-1:0] fold(input logic [KEY_W-1:0] k);
        logic [NCH*HW-1:0] p;
        logic [HW-1:0]     r;
        p = '0;
        p[KEY_W-1:0] = k;
        r = '0;
        for (int i = 0; i < NCH; i++) r = r ^ p[i*HW +: HW];
        return r;
    endfunction

    function automatic logic [KEY_W-1:0] rotl(input logic [KEY_W-1:0] k);
        logic [2*KEY_W-1:0] w;
        w = {k, k} >> (KEY_W - ROT);
        return w[KEY_W-1:0];
    endfunction

    assign q_maybe = bits_q[fold(q_key)] & bits_q[fold(rotl(q_key))];

    always_comb begin
        bits_d = bits_q;
        if (ins_en) begin
            bits_d[fold(ins_key)]       = 1'b1;
            bits_d[fold(rotl(ins_key))] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end
endmodule

// File: rtl/mdc_way_match.sv
module mdc_way_match #(
    parameter int KEY_W = 16,
    parameter int WAYS  = 4
) (
    input  logic [WAYS-1:0][KEY_W-1:0]   tags,
    input  logic [WAYS-1:0]              vld,
    input  logic [KEY_W-1:0]             key,
    output logic                         hit,
    output logic [$clog2(WAYS)-1:0]      way
);
    localparam int WAY_W = $clog2(WAYS);
    logic [WAYS-1:0] eq;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign eq[g] = vld[g] && (tags[g] == key);
    end

    always_comb begin
        hit = |eq;
        way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (eq[i]) way = WAY_W'(i);
        end
    end
endmodule

// File: rtl/mdc_victim.sv
module mdc_victim #(
    parameter int WAYS = 4
) (
    input  logic [WAYS-1:0]                         vld,
    input  logic [WAYS-1:0][$clog2(WAYS)-1:0]       age,
    output logic [$clog2(WAYS)-1:0]                 way
);
    localparam int WAY_W = $clog2(WAYS);

    always_comb begin
        way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (age[i] == WAY_W'(WAYS - 1)) way = WAY_W'(i);
        end
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!vld[i]) way = WAY_W'(i);
        end
    end
endmodule

// File: rtl/mdc_meta_cache.sv
module mdc_meta_cache
    import mdc_pkg::*;
#(
    parameter int KEY_W      = 16,
    parameter int VAL_W      = 16,
    parameter int SETS       = 16,
    parameter int WAYS       = 4,
    parameter int LINE_N     = 8,
    parameter int BLOOM_BITS = 1024
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_valid,
    output logic                    lk_ready,
    input  logic                    lk_write,
    input  logic [KEY_W-1:0]        lk_key,
    input  logic [VAL_W-1:0]        lk_wdata,
    output logic                    rs_valid,
    output logic                    rs_found,
    output logic [VAL_W-1:0]        rs_data,
    output logic                    filt_miss,
    output logic                    mem_req_valid,
    output logic                    mem_req_write,
    output logic [KEY_W-1:0]        mem_req_addr,
    output logic [VAL_W-1:0]        mem_req_wdata,
    input  logic                    mem_rsp_valid,
    input  logic [LINE_N*VAL_W-1:0] mem_rsp_data,
    input  logic [LINE_N-1:0]       mem_rsp_mask
);
    localparam int SET_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int LINE_W = $clog2(LINE_N);

    typedef struct packed {
        mdc_state_e                            st;
        logic [SETS-1:0][WAYS-1:0][KEY_W-1:0]  tag;
        logic [SETS-1:0][WAYS-1:0][VAL_W-1:0]  val;
        logic [SETS-1:0][WAYS-1:0]             vld;
        logic [SETS-1:0][WAYS-1:0]             dty;
        logic [SETS-1:0][WAYS-1:0][WAY_W-1:0]  age;
        logic [KEY_W-1:0]                      cur_key;
        logic [LINE_N*VAL_W-1:0]               line;
        logic [LINE_N-1:0]                     msk;
        logic [LINE_W-1:0]                     idx;
        logic                                  rs_valid;
        logic                                  rs_found;
        logic [VAL_W-1:0]                      rs_data;
        logic                                  filt;
        logic                                  mr_valid;
        logic                                  mr_write;
        logic [KEY_W-1:0]                      mr_addr;
        logic [VAL_W-1:0]                      mr_wdata;
    } state_t;

    state_t q, d;

    logic [KEY_W-1:0]  fill_key, probe_key;
    logic [SET_W-1:0]  ps;
    logic              hit, maybe;
    logic [WAY_W-1:0]  hway, vway;
    logic [LINE_W-1:0] req_slot;
    logic              ins_en;
    logic [KEY_W-1:0]  ins_key;
    logic              do_touch, do_alloc, a_dty;
    logic [WAY_W-1:0]  tw, a_old;
    logic [KEY_W-1:0]  a_key;
    logic [VAL_W-1:0]  a_val;

    assign fill_key  = {q.cur_key[KEY_W-1:LINE_W], q.idx};
    assign probe_key = (q.st == ST_FILL) ? fill_key : lk_key;
    assign ps        = probe_key[SET_W-1:0];
    assign req_slot  = q.cur_key[LINE_W-1:0];

    mdc_way_match #(.KEY_W(KEY_W), .WAYS(WAYS)) u_match (
        .tags (q.tag[ps]),
        .vld  (q.vld[ps]),
        .key  (probe_key),
        .hit  (hit),
        .way  (hway)
    );

    mdc_victim #(.WAYS(WAYS)) u_victim (
        .vld (q.vld[ps]),
        .age (q.age[ps]),
        .way (vway)
    );

    mdc_bloom #(.KEY_W(KEY_W), .BITS(BLOOM_BITS)) u_bloom (
        .clk     (clk),
        .rst_n   (rst_n),
        .q_key   (lk_key),
        .q_maybe (maybe),
        .ins_en  (ins_en),
        .ins_key (ins_key)
    );

    always_comb begin
        d          = q;
        d.rs_valid = 1'b0;
        d.rs_found = 1'b0;
        d.rs_data  = '0;
        d.filt     = 1'b0;
        d.mr_valid = 1'b0;
        d.mr_write = 1'b0;
        ins_en     = 1'b0;
        ins_key    = '0;
        do_touch   = 1'b0;
        tw         = '0;
        a_old      = '0;
        do_alloc   = 1'b0;
        a_key      = '0;
        a_val      = '0;
        a_dty      = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (lk_valid) begin
                    if (hit) begin
                        do_touch = 1'b1;
                        tw       = hway;
                        if (lk_write) begin
                            d.val[ps][hway] = lk_wdata;
                            d.dty[ps][hway] = 1'b1;
                        end else begin
                            d.rs_valid = 1'b1;
                            d.rs_found = 1'b1;
                            d.rs_data  = q.val[ps][hway];
                        end
                    end else if (lk_write) begin
                        do_alloc = 1'b1;
                        a_key    = lk_key;
                        a_val    = lk_wdata;
                        a_dty    = 1'b1;
                    end else if (maybe) begin
                        d.mr_valid = 1'b1;
                        d.mr_addr  = {lk_key[KEY_W-1:LINE_W], {LINE_W{1'b0}}};
                        d.cur_key  = lk_key;
                        d.st       = ST_WAIT;
                    end else begin
                        d.rs_valid = 1'b1;
                        d.filt     = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    d.line = mem_rsp_data;
                    d.msk  = mem_rsp_mask;
                    d.idx  = '0;
                    d.st   = ST_FILL;
                end
            end
            ST_FILL: begin
                if (q.msk[q.idx] && !hit) begin
                    do_alloc = 1'b1;
                    a_key    = fill_key;
                    a_val    = q.line[q.idx*VAL_W +: VAL_W];
                end
                if (q.idx == LINE_W'(LINE_N - 1)) begin
                    d.st       = ST_IDLE;
                    d.rs_valid = 1'b1;
                    d.rs_found = q.msk[req_slot];
                    d.rs_data  = q.msk[req_slot] ? q.line[req_slot*VAL_W +: VAL_W] : '0;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (do_alloc) begin
            if (q.vld[ps][vway] && q.dty[ps][vway]) begin
                d.mr_valid = 1'b1;
                d.mr_write = 1'b1;
                d.mr_addr  = q.tag[ps][vway];
                d.mr_wdata = q.val[ps][vway];
                ins_en     = 1'b1;
                ins_key    = q.tag[ps][vway];
            end
            d.tag[ps][vway] = a_key;
            d.val[ps][vway] = a_val;
            d.vld[ps][vway] = 1'b1;
            d.dty[ps][vway] = a_dty;
            do_touch        = 1'b1;
            tw              = vway;
        end

        if (do_touch) begin
            a_old = q.age[ps][tw];
            for (int j = 0; j < WAYS; j++) begin
                if (WAY_W'(j) == tw)             d.age[ps][j] = '0;
                else if (q.age[ps][j] < a_old)   d.age[ps][j] = q.age[ps][j] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) q.age[s][w] <= WAY_W'(w);
            end
        end else begin
            q <= d;
        end
    end

    assign lk_ready      = (q.st == ST_IDLE);
    assign rs_valid      = q.rs_valid;
    assign rs_found      = q.rs_found;
    assign rs_data       = q.rs_data;
    assign filt_miss     = q.filt;
    assign mem_req_valid = q.mr_valid;
    assign mem_req_write = q.mr_write;
    assign mem_req_addr  = q.mr_addr;
    assign mem_req_wdata = q.mr_wdata;
endmodule

// File: rtl/mdc_chk.sv
module mdc_chk (
    input logic clk,
    input logic rst_n,
    input logic lk_valid,
    input logic lk_ready,
    input logic lk_write,
    input logic rs_valid,
    input logic rs_found,
    input logic filt_miss,
    input logic mem_req_valid,
    input logic mem_req_write
);
    // R7
    filt_is_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        filt_miss |-> (rs_valid && !rs_found));

    // R2
    read_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready && !lk_write) |=> (rs_valid || (mem_req_valid && !mem_req_write)));

    // R3
    update_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready && lk_write) |=> !rs_valid);

    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write) |-> !lk_ready);

    // R6
    read_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write) |-> $past(lk_valid && lk_ready && !lk_write));
endmodule

bind mdc_meta_cache mdc_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_valid      (lk_valid),
    .lk_ready      (lk_ready),
    .lk_write      (lk_write),
    .rs_valid      (rs_valid),
    .rs_found      (rs_found),
    .filt_miss     (filt_miss),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write)
);

// File: tb/tb_mdc_meta_cache.sv
module tb_mdc_meta_cache;
    localparam int KW = 16;
    localparam int VW = 16;
    localparam int LN = 8;

    logic clk, rst_n;
    logic lk_valid, lk_ready, lk_write;
    logic [KW-1:0] lk_key;
    logic [VW-1:0] lk_wdata;
    logic rs_valid, rs_found, filt_miss;
    logic [VW-1:0] rs_data;
    logic mem_req_valid, mem_req_write;
    logic [KW-1:0] mem_req_addr;
    logic [VW-1:0] mem_req_wdata;
    logic mem_rsp_valid;
    logic [LN*VW-1:0] mem_rsp_data;
    logic [LN-1:0] mem_rsp_mask;

    mdc_meta_cache dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_write(lk_write),
        .lk_key(lk_key), .lk_wdata(lk_wdata),
        .rs_valid(rs_valid), .rs_found(rs_found), .rs_data(rs_data), .filt_miss(filt_miss),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_mask(mem_rsp_mask)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // bench memory: one mapping per key, keys below 256 only
    logic [VW-1:0] mval [256];
    bit            mpres [256];
    int            rd_cnt = 0;
    int            wr_cnt = 0;
    logic [KW-1:0] last_wkey, last_raddr;
    logic [VW-1:0] last_wdata;

    // per-read observations
    logic          g_req_seen;
    logic [KW-1:0] g_req_addr;
    logic          g_busy;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        int pend;
        pend = 0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        mem_rsp_mask  = '0;
        for (int i = 0; i < 256; i++) begin
            mval[i]  = '0;
            mpres[i] = 1'b0;
        end
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    for (int i = 0; i < LN; i++) begin
                        mem_rsp_data[i*VW +: VW] = mval[{last_raddr[7:3], 3'(i)}];
                        mem_rsp_mask[i]          = mpres[{last_raddr[7:3], 3'(i)}];
                    end
                    mem_rsp_valid = 1'b1;
                end
            end
            if (rst_n && mem_req_valid) begin
                if (mem_req_write) begin
                    wr_cnt++;
                    last_wkey  = mem_req_addr;
                    last_wdata = mem_req_wdata;
                    mval[mem_req_addr[7:0]]  = mem_req_wdata;
                    mpres[mem_req_addr[7:0]] = 1'b1;
                end else begin
                    rd_cnt++;
                    last_raddr = mem_req_addr;
                    pend = 3;
                end
            end
        end
    end

    task automatic do_update(input logic [KW-1:0] k, input logic [VW-1:0] v);
        while (!lk_ready) @(negedge clk);
        lk_valid = 1'b1; lk_write = 1'b1; lk_key = k; lk_wdata = v;
        @(negedge clk);
        lk_valid = 1'b0; lk_write = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_read(input logic [KW-1:0] k, output logic f, output logic [VW-1:0] dat,
                           output logic fl);
        int n;
        while (!lk_ready) @(negedge clk);
        lk_valid = 1'b1; lk_write = 1'b0; lk_key = k;
        @(negedge clk);
        lk_valid = 1'b0;
        g_req_seen = mem_req_valid && !mem_req_write;
        g_req_addr = mem_req_addr;
        g_busy = 1'b0;
        n = 0;
        while (!rs_valid && n < 60) begin
            if (!lk_ready) g_busy = 1'b1;
            @(negedge clk);
            n++;
        end
        f = rs_found; dat = rs_data; fl = filt_miss;
        if (n >= 60) chk("read response timeout", 32'(n), 32'd0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic f, fl; logic [VW-1:0] v; int rc;
        chk("R1 ready after reset", 32'(lk_ready), 32'd1);
        chk("R1 no response after reset", 32'(rs_valid), 32'd0);
        rc = rd_cnt;
        do_read(16'h0005, f, v, fl);
        chk("R1 empty read found", 32'(f), 32'd0);
        chk("R1 empty read filtered", 32'(fl), 32'd1);
        chk("R1 no memory read", 32'(rd_cnt - rc), 32'd0);
    endtask

    task automatic t_update_hit();
        logic f, fl; logic [VW-1:0] v; int rc;
        do_update(16'h0005, 16'hA005);
        do_update(16'h0015, 16'hA015);
        do_update(16'h0025, 16'hA025);
        do_update(16'h0035, 16'hA035);
        do_update(16'h0005, 16'hB005);
        rc = rd_cnt;
        do_read(16'h0005, f, v, fl);
        chk("R2 hit found", 32'(f), 32'd1);
        chk("R3 overwritten value", 32'(v), 32'hB005);
        chk("R2 hit not filtered", 32'(fl), 32'd0);
        chk("R2 hit no memory read", 32'(rd_cnt - rc), 32'd0);
    endtask

    task automatic t_lru();
        int wc;
        wc = wr_cnt;
        do_update(16'h0045, 16'hA045);
        chk("R4 one writeback", 32'(wr_cnt - wc), 32'd1);
        chk("R4 victim key is LRU", 32'(last_wkey), 32'h0015);
        chk("R4 victim data", 32'(last_wdata), 32'hA015);
    endtask

    task automatic t_filter();
        logic f, fl; logic [VW-1:0] v; int rc;
        rc = rd_cnt;
        do_read(16'h0063, f, v, fl);
        chk("R7 filtered found", 32'(f), 32'd0);
        chk("R7 filtered pulse", 32'(fl), 32'd1);
        chk("R7 no memory read", 32'(rd_cnt - rc), 32'd0);
    endtask

    task automatic t_fetch();
        logic f, fl; logic [VW-1:0] v; int rc;
        mval[8'h12] = 16'hC012; mpres[8'h12] = 1'b1;
        rc = rd_cnt;
        do_read(16'h0015, f, v, fl);
        chk("R6 memory read issued", 32'(g_req_seen), 32'd1);
        chk("R6 line address", 32'(g_req_addr), 32'h0010);
        chk("R6 exactly one read", 32'(rd_cnt - rc), 32'd1);
        chk("R10 not ready while fetching", 32'(g_busy), 32'd1);
        chk("R9 fetched found", 32'(f), 32'd1);
        chk("R9 fetched data", 32'(v), 32'hA015);
        chk("R9 not filtered", 32'(fl), 32'd0);
    endtask

    task automatic t_prefetch();
        logic f, fl; logic [VW-1:0] v; int rc;
        rc = rd_cnt;
        do_read(16'h0012, f, v, fl);
        chk("R8 neighbour hit", 32'(f), 32'd1);
        chk("R8 neighbour data", 32'(v), 32'hC012);
        chk("R8 no memory read", 32'(rd_cnt - rc), 32'd0);
    endtask

    task automatic t_clean();
        logic f, fl; logic [VW-1:0] v; int wc;
        do_update(16'h0022, 16'hA022);
        do_update(16'h0032, 16'hA032);
        do_update(16'h0042, 16'hA042);
        wc = wr_cnt;
        do_update(16'h0052, 16'hA052);
        chk("R5 clean victim no write", 32'(wr_cnt - wc), 32'd0);
        do_read(16'h0012, f, v, fl);
        chk("R5 clean victim gone", 32'(f), 32'd0);
        chk("R5 gone key filtered", 32'(fl), 32'd1);
    endtask

    task automatic t_keep();
        logic f, fl; logic [VW-1:0] v; int wc;
        do_update(16'h0031, 16'hD031);
        mval[8'h31] = 16'hE031; mpres[8'h31] = 1'b1;
        do_update(16'h0036, 16'hD036);
        do_update(16'h0046, 16'hD046);
        do_update(16'h0056, 16'hD056);
        do_update(16'h0066, 16'hD066);
        wc = wr_cnt;
        do_update(16'h0076, 16'hD076);
        chk("R4 set 6 writeback key", 32'(last_wkey), 32'h0036);
        chk("R4 set 6 one write", 32'(wr_cnt - wc), 32'd1);
        do_read(16'h0036, f, v, fl);
        chk("R6 line address 0x30", 32'(g_req_addr), 32'h0030);
        chk("R9 slot 6 found", 32'(f), 32'd1);
        chk("R9 slot 6 data", 32'(v), 32'hD036);
        do_read(16'h0031, f, v, fl);
        chk("R11 resident kept found", 32'(f), 32'd1);
        chk("R11 resident value kept", 32'(v), 32'hD031);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        lk_valid = 1'b0; lk_write = 1'b0; lk_key = '0; lk_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_update_hit();
        t_lru();
        t_filter();
        t_fetch();
        t_prefetch();
        t_clean();
        t_keep();
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule